// File: doc/BRIEF.md
# Paged Microcode Register Interface

This block is the 32-bit memory-mapped slave face of a programmable vertex processor. A byte address is turned into a word index, and that index lands in one of three regions. The first is a small bank of control and status words. The second is a direct window onto the 128 general registers. The third is a 512-word window into a 2048-word microcode store. The window's page is picked by the low bits of a programmable page register, so the whole store is reached as four pages of 512 words.

Writing the control word with bit 0 set sends a one-cycle launch pulse to the compute engine. Reading the control word returns the engine's busy level and a sticky error flag. The engine sits outside this block and reaches it through its own ports: configuration outputs and two read ports, one into the general registers and one into the microcode store. Any access to an index outside the three regions returns zero, changes nothing and sets the error flag.

Top module: `ucode_regif`

## Requirements
- R1: After reset, every control word, general register and microcode word reads as zero. The error flag and the launch pulse are low.
- R2: A read request (req_i high, we_i low) is answered in the next cycle with rvalid_o high and the data on rdata_o. rvalid_o is low in every other cycle.
- R3: Control word indices 1 to 11 are plain 32-bit storage that reads back what was written. Index 1 drives mesh_base_o, index 2 drives hmesh_last_o and index 3 drives vmesh_last_o.
- R4: Word indices 0x100 to 0x17F reach general register (index − 0x100). The engine port eng_gpr_addr_i sees the same contents.
- R5: Word indices 0x200 to 0x3FF reach microcode entry 512 × P + (index − 0x200), where P is bits [1:0] of control word 4. The upper bits of control word 4 have no effect on the translation. The engine port eng_uc_addr_i addresses all 2048 entries directly.
- R6: A write to index 0 with bit 0 set raises start_o for exactly the one cycle after the write. A write to index 0 with bit 0 clear raises no pulse.
- R7: A read of index 0 returns busy_i in bit 0, the error flag in bit 1, and zero in all other bits.
- R8: An access to an unmapped index (12 to 0xFF, or 0x180 to 0x1FF) reads as zero, writes nothing and sets err_o in the next cycle. err_o stays set until index 0 is read; that read still reports it, and err_o is low from the next cycle.
- R9: The word index is addr_i[11:2]. Byte address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Sticky unmapped-access flag |
| start_o | output | 1 | One-cycle launch pulse to the engine |
| busy_i | input | 1 | Engine busy level |
| mesh_base_o | output | 32 | Control word 1 |
| hmesh_last_o | output | 32 | Control word 2 |
| vmesh_last_o | output | 32 | Control word 3 |
| eng_gpr_addr_i | input | 7 | Engine general register read address |
| eng_gpr_data_o | output | 32 | Engine general register read data |
| eng_uc_addr_i | input | 11 | Engine microcode read address |
| eng_uc_data_o | output | 32 | Engine microcode read data |

## Verification
A wrong page translation shows at the engine microcode port as soon as the write completes. A word written through page 1 appears at entry 0 instead of entry 512, and reading it back with a different page selected returns the wrong value one cycle later. A wrong decode shows as an aliased write: data written to an unmapped index shows up in a general register or control word, or an unmapped read comes back non-zero. A stuck or mistimed error flag or launch pulse shows on err_o or start_o in the cycle right after the access that should change it.

// File: rtl/regif_pkg.sv
package regif_pkg;
  typedef enum logic [1:0] {
    RGN_CSR   = 2'd0,
    RGN_GPR   = 2'd1,
    RGN_UCODE = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;

  localparam int CSR_COUNT    = 12;
  localparam int CSR_CTL      = 0;
  localparam int CSR_MESHBASE = 1;
  localparam int CSR_HLAST    = 2;
  localparam int CSR_VLAST    = 3;
  localparam int CSR_PAGE     = 4;
endpackage

// File: rtl/regif_decode.sv
module regif_decode
  import regif_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int GPR_BASE  = 'h100,
  parameter int GPR_DEPTH = 128,
  parameter int UC_BASE   = 'h200,
  parameter int UC_WIN    = 512,
  parameter int PAGE_W    = 2,
  localparam int GPR_AW   = $clog2(GPR_DEPTH),
  localparam int WIN_AW   = $clog2(UC_WIN),
  localparam int UC_AW    = WIN_AW + PAGE_W,
  localparam int SEL_W    = $clog2(CSR_COUNT)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [PAGE_W-1:0] page,
  output region_e           region,
  output logic [SEL_W-1:0]  csr_sel,
  output logic [GPR_AW-1:0] gpr_addr,
  output logic [UC_AW-1:0]  uc_addr
);
  logic [IDX_W-1:0] gpr_off;
  logic [IDX_W-1:0] uc_off;
  int unsigned      idx_u;

  always_comb begin
    idx_u    = int'(idx);
    gpr_off  = idx - IDX_W'(GPR_BASE);
    uc_off   = idx - IDX_W'(UC_BASE);
    csr_sel  = idx[SEL_W-1:0];
    gpr_addr = gpr_off[GPR_AW-1:0];
    uc_addr  = {page, uc_off[WIN_AW-1:0]};
    if (idx_u < CSR_COUNT)
      region = RGN_CSR;
    else if (idx_u >= GPR_BASE && idx_u < GPR_BASE + GPR_DEPTH)
      region = RGN_GPR;
    else if (idx_u >= UC_BASE && idx_u < UC_BASE + UC_WIN)
      region = RGN_UCODE;
    else
      region = RGN_NONE;
  end
endmodule

// File: rtl/regif_store.sv
module regif_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic en;
    assign en = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (en)
        mem_q[i] <= wdata;
    end
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];
endmodule

// File: rtl/regif_csr.sv
module regif_csr
  import regif_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PAGE_W = 2,
  localparam int SEL_W = $clog2(CSR_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DW-1:0]     wdata,
  input  logic              bad_hit,
  input  logic              busy_i,
  output logic [DW-1:0]     rdata,
  output logic              start_o,
  output logic              err_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [DW-1:0]     mesh_base_o,
  output logic [DW-1:0]     hlast_o,
  output logic [DW-1:0]     vlast_o
);
  logic [DW-1:0] word_q [1:CSR_COUNT-1];
  logic          start_q, start_d;
  logic          err_q, err_d;
  logic          ctl_sel;

  assign ctl_sel = (sel == SEL_W'(CSR_CTL));

  for (genvar i = 1; i < CSR_COUNT; i++) begin : g_csr
    logic en;
    assign en = wr_en && (sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[i] <= '0;
      else if (en)
        word_q[i] <= wdata;
    end
  end

  always_comb begin
    start_d = wr_en && ctl_sel && wdata[0];
    err_d   = err_q;
    if (bad_hit)
      err_d = 1'b1;
    else if (rd_en && ctl_sel)
      err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (ctl_sel)
      rdata = {{(DW-2){1'b0}}, err_q, busy_i};
    else if (int'(sel) < CSR_COUNT)
      rdata = word_q[sel];
  end

  logic [DW-1:0] page_word;
  assign page_word   = word_q[CSR_PAGE];
  assign page_o      = page_word[PAGE_W-1:0];
  assign mesh_base_o = word_q[CSR_MESHBASE];
  assign hlast_o     = word_q[CSR_HLAST];
  assign vlast_o     = word_q[CSR_VLAST];
  assign start_o     = start_q;
  assign err_o       = err_q;

  logic unused_page_hi;
  assign unused_page_hi = ^page_word[DW-1:PAGE_W];
endmodule

// File: rtl/ucode_regif.sv
module ucode_regif
  import regif_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DW        = 32,
  parameter int GPR_DEPTH = 128,
  parameter int UC_DEPTH  = 2048,
  parameter int UC_WIN    = 512,
  parameter int GPR_BASE  = 'h100,
  parameter int UC_BASE   = 'h200,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int GPR_AW   = $clog2(GPR_DEPTH),
  localparam int UC_AW    = $clog2(UC_DEPTH),
  localparam int PAGE_W   = $clog2(UC_DEPTH / UC_WIN),
  localparam int SEL_W    = $clog2(CSR_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              start_o,
  input  logic              busy_i,
  output logic [DW-1:0]     mesh_base_o,
  output logic [DW-1:0]     hmesh_last_o,
  output logic [DW-1:0]     vmesh_last_o,
  input  logic [GPR_AW-1:0] eng_gpr_addr_i,
  output logic [DW-1:0]     eng_gpr_data_o,
  input  logic [UC_AW-1:0]  eng_uc_addr_i,
  output logic [DW-1:0]     eng_uc_data_o
);
  region_e           region;
  logic [SEL_W-1:0]  csr_sel;
  logic [GPR_AW-1:0] gpr_addr;
  logic [UC_AW-1:0]  uc_addr;
  logic [PAGE_W-1:0] page;
  logic [DW-1:0]     csr_rd, gpr_rd, uc_rd, rd_mux;
  logic              rd_en, wr_en;
  logic              rvalid_q, rvalid_d;
  logic [DW-1:0]     rdata_q, rdata_d;

  assign rd_en = req_i && !we_i;
  assign wr_en = req_i && we_i;

  regif_decode #(
    .IDX_W(IDX_W), .GPR_BASE(GPR_BASE), .GPR_DEPTH(GPR_DEPTH),
    .UC_BASE(UC_BASE), .UC_WIN(UC_WIN), .PAGE_W(PAGE_W)
  ) u_dec (
    .idx(addr_i[ADDR_W-1:2]), .page(page), .region(region),
    .csr_sel(csr_sel), .gpr_addr(gpr_addr), .uc_addr(uc_addr)
  );

  regif_csr #(.DW(DW), .PAGE_W(PAGE_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && region == RGN_CSR),
    .rd_en(rd_en && region == RGN_CSR),
    .sel(csr_sel), .wdata(wdata_i),
    .bad_hit(req_i && region == RGN_NONE),
    .busy_i(busy_i), .rdata(csr_rd), .start_o(start_o), .err_o(err_o),
    .page_o(page), .mesh_base_o(mesh_base_o),
    .hlast_o(hmesh_last_o), .vlast_o(vmesh_last_o)
  );

  regif_store #(.DEPTH(GPR_DEPTH), .DW(DW)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && region == RGN_GPR), .waddr(gpr_addr), .wdata(wdata_i),
    .ra_addr(gpr_addr), .ra_data(gpr_rd),
    .rb_addr(eng_gpr_addr_i), .rb_data(eng_gpr_data_o)
  );

  regif_store #(.DEPTH(UC_DEPTH), .DW(DW)) u_uc (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && region == RGN_UCODE), .waddr(uc_addr), .wdata(wdata_i),
    .ra_addr(uc_addr), .ra_data(uc_rd),
    .rb_addr(eng_uc_addr_i), .rb_data(eng_uc_data_o)
  );

  always_comb begin
    case (region)
      RGN_CSR:   rd_mux = csr_rd;
      RGN_GPR:   rd_mux = gpr_rd;
      RGN_UCODE: rd_mux = uc_rd;
      default:   rd_mux = '0;
    endcase
    rvalid_d = rd_en;
    rdata_d  = rd_en ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  logic unused_byte_lane;
  assign unused_byte_lane = ^addr_i[1:0];
endmodule

// File: rtl/regif_checker.sv
module regif_checker #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit0,
  input logic              rvalid_o,
  input logic [DW-1:0]     rdata_o,
  input logic              err_o,
  input logic              start_o
);
  int unsigned idx;
  logic        unmapped, ctl_hit;

  always_comb begin
    idx      = int'(addr_i[ADDR_W-1:2]);
    unmapped = !((idx < 12) || (idx >= 'h100 && idx < 'h180) || (idx >= 'h200 && idx < 'h400));
    ctl_hit  = (idx == 0);
  end

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!start_o && !err_o && !rvalid_o);

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> rvalid_o);
  assert_rvalid_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !we_i) |=> !rvalid_o);
  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_start_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && ctl_hit && wbit0) |=> start_o);
  assert_start_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && we_i && ctl_hit && wbit0) |=> !start_o);
  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && unmapped) |=> err_o);
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && ctl_hit) |=> !err_o);
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(req_i && !we_i && ctl_hit)) |=> err_o);
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && unmapped) |=> (rdata_o == '0));
endmodule

bind ucode_regif regif_checker #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wbit0(wdata_i[0]), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
  .err_o(err_o), .start_o(start_o)
);

// File: tb/tb_ucode_regif.sv
module tb_ucode_regif;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, we_i, busy_i;
  logic [11:0] addr_i;
  logic [31:0] wdata_i;
  logic        rvalid_o, err_o, start_o;
  logic [31:0] rdata_o, mesh_base_o, hmesh_last_o, vmesh_last_o;
  logic [6:0]  eng_gpr_addr_i;
  logic [31:0] eng_gpr_data_o;
  logic [10:0] eng_uc_addr_i;
  logic [31:0] eng_uc_data_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ucode_regif dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [1:0] lane = 2'b00);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'((idx << 2) | int'(lane)); wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d, input logic [1:0] lane = 2'b00);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = 12'((idx << 2) | int'(lane));
    @(negedge clk);
    req_i = 1'b0;
    chk("R2 rvalid", 32'(rvalid_o), 32'd1);
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 start", 32'(start_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 rvalid", 32'(rvalid_o), 0);
    eng_gpr_addr_i = 7'd5; eng_uc_addr_i = 11'd1500; #1;
    chk("R1 eng gpr", eng_gpr_data_o, 0);
    chk("R1 eng uc", eng_uc_data_o, 0);
    rd(4, v);      chk("R1 csr4", v, 0);
    rd('h105, v);  chk("R1 gpr5", v, 0);
    rd('h3FF, v);  chk("R1 uc", v, 0);
    rd(0, v);      chk("R7 ctl idle", v, 0);
    @(negedge clk);
    chk("R2 rvalid low when idle", 32'(rvalid_o), 0);
  endtask

  task automatic t_csr;
    logic [31:0] v;
    for (int i = 1; i < 12; i++) wr(i, 32'hA500_0000 | 32'(i * 'h111));
    for (int i = 1; i < 12; i++) begin
      rd(i, v);
      chk("R3 csr readback", v, 32'hA500_0000 | 32'(i * 'h111));
    end
    chk("R3 mesh_base", mesh_base_o, 32'hA500_0111);
    chk("R3 hlast", hmesh_last_o, 32'hA500_0222);
    chk("R3 vlast", vmesh_last_o, 32'hA500_0333);
    chk("R6 no start from csr writes", 32'(start_o), 0);
    wr(4, 32'h0);
  endtask

  task automatic t_gpr;
    logic [31:0] v;
    wr('h100, 32'h1111_0000);
    wr('h17F, 32'h2222_007F);
    wr('h140, 32'h3333_0040);
    rd('h17F, v); chk("R4 gpr127 read", v, 32'h2222_007F);
    eng_gpr_addr_i = 7'd0;  #1; chk("R4 eng gpr0", eng_gpr_data_o, 32'h1111_0000);
    eng_gpr_addr_i = 7'd64; #1; chk("R4 eng gpr64", eng_gpr_data_o, 32'h3333_0040);
    wr('h101, 32'hBEEF_0001, 2'b11);
    rd('h101, v, 2'b10); chk("R9 byte lane ignored", v, 32'hBEEF_0001);
    eng_gpr_addr_i = 7'd1; #1; chk("R9 eng gpr1", eng_gpr_data_o, 32'hBEEF_0001);
  endtask

  task automatic t_ucode;
    logic [31:0] v;
    wr(4, 0); wr('h200, 32'hC0DE_0000);
    wr(4, 1); wr('h200, 32'hC0DE_0200);
    wr(4, 3); wr('h3FF, 32'hC0DE_07FF);
    wr(4, 2); wr('h210, 32'hC0DE_0410);
    eng_uc_addr_i = 11'd0;    #1; chk("R5 page0 entry0", eng_uc_data_o, 32'hC0DE_0000);
    eng_uc_addr_i = 11'd512;  #1; chk("R5 page1 entry512", eng_uc_data_o, 32'hC0DE_0200);
    eng_uc_addr_i = 11'd2047; #1; chk("R5 page3 entry2047", eng_uc_data_o, 32'hC0DE_07FF);
    eng_uc_addr_i = 11'd1040; #1; chk("R5 page2 entry1040", eng_uc_data_o, 32'hC0DE_0410);
    wr(4, 32'hFFFF_FFF5);
    rd('h200, v); chk("R5 page upper bits ignored", v, 32'hC0DE_0200);
    wr(4, 0);
    rd('h200, v); chk("R5 page0 readback", v, 32'hC0DE_0000);
  endtask

  task automatic t_start;
    logic [31:0] v;
    wr(0, 32'h0000_0001);
    chk("R6 start pulse high", 32'(start_o), 1);
    @(negedge clk);
    chk("R6 start pulse one cycle", 32'(start_o), 0);
    wr(0, 32'hFFFF_FFFE);
    chk("R6 bit0 clear no pulse", 32'(start_o), 0);
    busy_i = 1'b1;
    rd(0, v); chk("R7 busy bit", v, 32'h1);
    busy_i = 1'b0;
    rd(0, v); chk("R7 ctl other bits zero", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr('h180, 32'hDEAD_DEAD);
    chk("R8 err set by write", 32'(err_o), 1);
    eng_gpr_addr_i = 7'd0; eng_uc_addr_i = 11'd384; #1;
    chk("R8 write no alias gpr", eng_gpr_data_o, 32'h1111_0000);
    chk("R8 write no alias uc", eng_uc_data_o, 0);
    rd('h180, v); chk("R8 unmapped reads zero", v, 0);
    rd(12, v);    chk("R8 idx12 reads zero", v, 0);
    rd('h0FF, v); chk("R8 idx 0xFF reads zero", v, 0);
    chk("R8 err sticky", 32'(err_o), 1);
    rd(0, v); chk("R7 ctl reports err", v, 32'h2);
    chk("R8 err cleared by ctl read", 32'(err_o), 0);
    rd(0, v); chk("R8 err stays clear", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; busy_i = 1'b0;
    addr_i = '0; wdata_i = '0; eng_gpr_addr_i = '0; eng_uc_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csr();
    t_gpr();
    t_ucode();
    t_start();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule